// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked, synthesizable model of a 16-bit static memory with two byte lanes and a small internal array. Its address can be loaded by either of two strobes. One is a processor-side strobe, which is gated by the master chip enable. The other is a controller-side strobe, which is not gated. A loaded access then steps through a four-word burst, in linear or interleaved order. Every clocked cycle after a load is one data phase. In that phase the write controls decide whether the word at the current burst address is read, or whether one or both of its byte lanes are written.

The read path has two latencies. In flow-through mode the data passes through one register stage. In pipelined mode it passes through two. The output drive is gated by an asynchronous output enable. The data bus is modelled as separate input, output and drive-enable ports. A snooze input freezes all clocked state, including the array, and silences the outputs. When snooze is released, the device carries on exactly where it stopped.

Top module: `sbsram_core`

## Requirements
- R1: After reset the chip is deselected: `dout_en` is 0 and `dout` is 0.
- R2: At a rising edge with snooze low, an address load happens when `strobe_ctl_n` is 0, or when `strobe_cpu_n` is 0 and `ce_main_n` is 0. With `ce_main_n` at 1, `strobe_cpu_n` alone has no effect: the current burst address and the selection state are kept.
- R3: If a load happens while any of `ce_main_n`=0, `ce_hi`=1, `ce_lo_n`=0 fails, the chip becomes deselected. Later data phases neither write nor drive the bus until the next selected load.
- R4: In a data phase, `wr_all_n`=0 writes both lanes from `din`, whatever `wr_bytes_n` and `lane_wr_n` are. Such a cycle yields no read data.
- R5: With `wr_all_n`=1 and `wr_bytes_n`=0, bit i of `lane_wr_n` at 0 writes lane i. Lane 0 is `din[7:0]` and lane 1 is `din[15:8]`. If no lane bit is 0, or if `wr_bytes_n`=1, the cycle is a read.
- R6: With `flow_n`=0, the word read in a data phase is on `dout` right after that phase's closing edge, which is one edge after the load for the first word.
- R7: With `flow_n`=1, read data appears one edge later than in R6, which is two edges after the load for the first word.
- R8: `dout_en` is 1 only while valid read data is present, `oe_n` is 0 and snooze is low. `oe_n` acts without a clock. While `dout_en` is 0, `dout` is 0.
- R9: With `order_xor`=0, the burst visits the low two address bits as (start+k) mod 4 for k=0..3, and then wraps. The upper bits stay fixed.
- R10: With `order_xor`=1, the burst visits the low two address bits as start XOR k.
- R11: While `snooze` is 1, the outputs are silent and clock edges change nothing: not the array, not the burst position, not the read pipeline. Stored data is retained.
- R12: A data phase with `adv_n`=1 keeps the burst address, so the next phase accesses the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Word address, taken on a load |
| ce_main_n | input | 1 | Master chip enable, active low; gates the processor strobe |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_bytes_n | input | 1 | Enables the per-lane write bits, active low |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | 0 selects flow-through reads, 1 selects pipelined reads |
| order_xor | input | 1 | 0 selects linear burst order, 1 selects interleaved order |
| snooze | input | 1 | Low-power hold; contents are kept |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive enable |

## Verification
The latency properties assume that `flow_n` and `order_xor` are static configuration inputs. They must not change between a read phase and the edge on which its data lands. The bench therefore changes them only while the chip is deselected, between bursts. The processor-strobe blocking property assumes that the controller strobe is idle and `adv_n` is high in the same cycle, and the directed test keeps to that. The bench sweeps every start address under both burst orders, alternating the read mode, against a reference array it keeps itself. It also exercises each write-control combination, the strobe gating, the asynchronous enable and a snooze window in which edges carry writes and loads that must all be ignored.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int BURST_BITS = 2;

  typedef logic [BURST_BITS-1:0] burst_ofs_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  // Low address bits for burst step 'step' from start offset 'start'.
  function automatic burst_ofs_t burst_offset(burst_ofs_t start, burst_ofs_t step,
                                              burst_order_e order);
    burst_ofs_t res;
    if (order == ORDER_XOR) res = start ^ step;
    else                    res = start + step;
    return res;
  endfunction

  // Three-level write decode for a single lane (all controls active low).
  function automatic logic lane_write(logic all_n, logic bytes_n, logic lane_n);
    return (!all_n) || (!bytes_n && !lane_n);
  endfunction

endpackage

// File: rtl/sbsram_select.sv
module sbsram_select (
  input  logic snooze,
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic ce_main_n,
  input  logic ce_hi,
  input  logic ce_lo_n,
  output logic start,
  output logic chip_sel
);

  logic cpu_req;
  logic ctl_req;

  // The processor strobe only counts while the master enable is active.
  assign cpu_req  = !strobe_cpu_n && !ce_main_n;
  assign ctl_req  = !strobe_ctl_n;
  assign start    = !snooze && (cpu_req || ctl_req);
  assign chip_sel = !ce_main_n && ce_hi && !ce_lo_n;

endmodule

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              advance,
  input  burst_order_e      order,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0] base_q;
  burst_ofs_t        step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (!hold) begin
      if (load) begin
        base_q <= base_in;
        step_q <= '0;
      end else if (advance) begin
        step_q <= step_q + burst_ofs_t'(1);
      end
    end
  end

  assign cur_addr = {base_q[ADDR_W-1 -: HI_W],
                     burst_offset(base_q[BURST_BITS-1:0], step_q, order)};

endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] wr_en,
  output logic             wr_any
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_en[g] = lane_write(wr_all_n, wr_bytes_n, lane_wr_n[g]);
  end

  assign wr_any = |wr_en;

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/sbsram_read_path.sv
module sbsram_read_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              rd_evt,
  input  logic [DATA_W-1:0] rdata,
  input  logic              flow_n,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  logic [DATA_W-1:0] stage1_q;
  logic [DATA_W-1:0] stage2_q;
  logic              vld1_q;
  logic              vld2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      vld1_q   <= 1'b0;
      vld2_q   <= 1'b0;
    end else if (!hold) begin
      vld1_q   <= rd_evt;
      stage1_q <= rd_evt ? rdata : stage1_q;
      vld2_q   <= vld1_q;
      stage2_q <= stage1_q;
    end
  end

  assign out_data  = flow_n ? stage2_q : stage1_q;
  assign out_valid = flow_n ? vld2_q   : vld1_q;

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce_main_n,
  input  logic                    ce_hi,
  input  logic                    ce_lo_n,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_bytes_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic                    flow_n,
  input  logic                    order_xor,
  input  logic                    snooze,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  logic              start;
  logic              chip_sel;
  logic              active_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  wr_en;
  logic              wr_any;
  logic [LANES-1:0]  mem_we;
  logic              rd_evt;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;

  sbsram_select u_select (
    .snooze       (snooze),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .ce_main_n    (ce_main_n),
    .ce_hi        (ce_hi),
    .ce_lo_n      (ce_lo_n),
    .start        (start),
    .chip_sel     (chip_sel)
  );

  // Selection state: set by a selected load, cleared by a deselected one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                active_q <= 1'b0;
    else if (!snooze && start) active_q <= chip_sel;
  end

  sbsram_burst_seq #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (snooze),
    .load     (start && chip_sel),
    .base_in  (addr),
    .advance  (active_q && !adv_n),
    .order    (burst_order_e'(order_xor)),
    .cur_addr (cur_addr)
  );

  sbsram_wr_decode #(.LANES(LANES)) u_wrdec (
    .wr_all_n   (wr_all_n),
    .wr_bytes_n (wr_bytes_n),
    .lane_wr_n  (lane_wr_n),
    .wr_en      (wr_en),
    .wr_any     (wr_any)
  );

  assign mem_we = (active_q && !snooze) ? wr_en : '0;
  assign rd_evt = active_q && !wr_any;

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .addr  (cur_addr),
    .wdata (din),
    .rdata (mem_rdata)
  );

  sbsram_read_path #(.DATA_W(DATA_W)) u_rdpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (snooze),
    .rd_evt    (rd_evt),
    .rdata     (mem_rdata),
    .flow_n    (flow_n),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  assign dout_en = out_valid && !oe_n && !snooze;
  assign dout    = dout_en ? out_data : '0;

endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_main_n,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic              wr_all_n,
  input logic              wr_bytes_n,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              oe_n,
  input logic              flow_n,
  input logic              snooze,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              start,
  input logic              chip_sel,
  input logic              active_q,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANES-1:0]  wr_en,
  input logic              wr_any,
  input logic              rd_evt,
  input logic              out_valid
);

  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && chip_sel) |=> (active_q && cur_addr == $past(addr)));

  p_cpu_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && ce_main_n && strobe_ctl_n && adv_n && !snooze)
      |=> ($stable(cur_addr) && $stable(active_q)));

  p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !chip_sel) |=> !active_q);

  p_global_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_all_n |-> (wr_en == '1));

  p_no_lane_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_n && !wr_bytes_n && lane_wr_n == '1) |-> !wr_any);

  p_flow_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !snooze && !flow_n) |=> (out_valid || flow_n));

  p_pipe_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_evt) && !$past(snooze) && !snooze && flow_n) |=> out_valid);

  p_snooze_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> ($stable(cur_addr) && $stable(active_q) && $stable(out_valid)));

  p_snooze_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !dout_en);

endmodule

bind sbsram_core sbsram_core_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .ce_main_n    (ce_main_n),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .adv_n        (adv_n),
  .wr_all_n     (wr_all_n),
  .wr_bytes_n   (wr_bytes_n),
  .lane_wr_n    (lane_wr_n),
  .oe_n         (oe_n),
  .flow_n       (flow_n),
  .snooze       (snooze),
  .dout         (dout),
  .dout_en      (dout_en),
  .start        (start),
  .chip_sel     (chip_sel),
  .active_q     (active_q),
  .cur_addr     (cur_addr),
  .wr_en        (wr_en),
  .wr_any       (wr_any),
  .rd_evt       (rd_evt),
  .out_valid    (out_valid)
);

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        ce_main_n, ce_hi, ce_lo_n;
  logic        strobe_cpu_n, strobe_ctl_n, adv_n;
  logic        wr_all_n, wr_bytes_n;
  logic [1:0]  lane_wr_n;
  logic        oe_n, flow_n, order_xor, snooze;
  logic [15:0] din;
  logic [15:0] dout;
  logic        dout_en;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_mem [64];

  always #4 clk = ~clk;

  sbsram_core u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_main_n(ce_main_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .lane_wr_n(lane_wr_n),
    .oe_n(oe_n), .flow_n(flow_n), .order_xor(order_xor), .snooze(snooze),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] seq_addr(logic [5:0] b, bit xo, int k);
    int lo;
    if (xo) lo = int'(b % 4) ^ k;
    else    lo = (int'(b % 4) + k) % 4;
    return 6'((int'(b) / 4) * 4 + lo);
  endfunction

  function automatic logic [15:0] pat(logic [5:0] a, logic [15:0] seed);
    return 16'((int'(a) * 2749 + 91) % 65536) ^ seed;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
    wr_all_n = 1; wr_bytes_n = 1; lane_wr_n = 2'b11;
  endtask

  task automatic load(logic [5:0] a);
    addr = a; strobe_ctl_n = 0; step(); strobe_ctl_n = 1;
  endtask

  task automatic deselect();
    idle(); ce_hi = 0; strobe_ctl_n = 0; step(); ce_hi = 1; strobe_ctl_n = 1;
  endtask

  task automatic bwrite(logic [5:0] b, bit xo, logic [15:0] seed);
    order_xor = xo;
    load(b);
    for (int k = 0; k < 4; k++) begin
      logic [5:0] a;
      a = seq_addr(b, xo, k);
      wr_all_n = 0; adv_n = 0; din = pat(a, seed);
      ref_mem[a] = din;
      step();
    end
    deselect();
  endtask

  task automatic bread(logic [5:0] b, bit xo, bit fl);
    flow_n = fl; order_xor = xo;
    load(b);
    adv_n = 0;
    for (int j = 1; j <= 5; j++) begin
      step();
      if (!fl && j <= 4) begin
        chk(xo ? "R10 flow drive R6" : "R9 flow drive R6", 16'(dout_en), 16'd1);
        chk(xo ? "R10 flow data R6" : "R9 flow data R6", dout, ref_mem[seq_addr(b, xo, j - 1)]);
      end
      if (fl && j >= 2) begin
        chk(xo ? "R10 pipe drive R7" : "R9 pipe drive R7", 16'(dout_en), 16'd1);
        chk(xo ? "R10 pipe data R7" : "R9 pipe data R7", dout, ref_mem[seq_addr(b, xo, j - 2)]);
      end
    end
    deselect();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; addr = 0; ce_main_n = 0; ce_hi = 1; ce_lo_n = 0;
    oe_n = 0; flow_n = 0; order_xor = 0; snooze = 0; din = 0;
    idle();
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 drive", 16'(dout_en), 16'd0);
    chk("R1 data", dout, 16'd0);

    // Fill the array, then overwrite one block in interleaved order.
    for (int b = 0; b < 64; b += 4) bwrite(6'(b), 1'b0, 16'h1357);
    bwrite(6'd6, 1'b1, 16'hA0A0);

    // Sweep every start address in both orders, alternating read mode.
    for (int xo = 0; xo < 2; xo++)
      for (int b = 0; b < 64; b++)
        bread(6'(b), xo[0], b[0]);

    // Write-control decode, flow-through, burst held (adv_n high).
    flow_n = 0;
    load(6'd5);
    wr_bytes_n = 0; lane_wr_n = 2'b10; din = 16'hC3C3;
    ref_mem[5][7:0] = 8'hC3;
    step();
    idle(); step();
    chk("R5 lane0 write", dout, ref_mem[5]);
    wr_bytes_n = 0; lane_wr_n = 2'b11; din = 16'hFFFF; step();
    chk("R5 no lane is read", 16'(dout_en), 16'd1);
    chk("R5 no lane keeps data", dout, ref_mem[5]);
    wr_bytes_n = 1; lane_wr_n = 2'b00; din = 16'h0000; step();
    chk("R5 lanes ignored without byte enable", dout, ref_mem[5]);
    wr_all_n = 0; wr_bytes_n = 1; lane_wr_n = 2'b01; din = 16'h1234;
    ref_mem[5] = 16'h1234;
    step();
    chk("R4 write gives no read data", 16'(dout_en), 16'd0);
    idle(); step();
    chk("R4 both lanes written", dout, 16'h1234);
    wr_bytes_n = 0; lane_wr_n = 2'b01; din = 16'hABCD;
    ref_mem[5][15:8] = 8'hAB;
    step();
    idle(); step();
    chk("R5 lane1 write", dout, 16'hAB34);
    chk("R12 same word repeated", dout, ref_mem[5]);
    deselect();

    // Processor strobe: loads when master enable active, blocked otherwise.
    addr = 6'd9; strobe_cpu_n = 0; step(); strobe_cpu_n = 1;
    addr = 6'd40; strobe_cpu_n = 0; ce_main_n = 1; step();
    chk("R2 cpu strobe load", dout, ref_mem[9]);
    step();
    chk("R2 cpu strobe blocked", dout, ref_mem[9]);
    strobe_cpu_n = 1; ce_main_n = 0;
    step();
    chk("R12 hold address", dout, ref_mem[9]);

    // Deselected load: no writes, no drive.
    idle(); ce_lo_n = 1; load(6'd12); ce_lo_n = 0;
    wr_all_n = 0; din = 16'hDEAD; step();
    chk("R3 no drive when deselected", 16'(dout_en), 16'd0);
    step();
    chk("R3 still quiet", 16'(dout_en), 16'd0);
    idle();
    load(6'd12); step();
    chk("R3 write blocked", dout, ref_mem[12]);
    deselect();

    // Asynchronous output enable.
    load(6'd20); step(); step();
    chk("R8 driven", dout, ref_mem[20]);
    oe_n = 1; #1;
    chk("R8 oe off drive", 16'(dout_en), 16'd0);
    chk("R8 oe off data", dout, 16'd0);
    oe_n = 0; #1;
    chk("R8 oe back", dout, ref_mem[20]);

    // Snooze: edges carry a write and a load, all ignored.
    adv_n = 0; snooze = 1; #1;
    chk("R11 quiet in snooze", 16'(dout_en), 16'd0);
    wr_all_n = 0; din = 16'h0000; addr = 6'd33; strobe_ctl_n = 0;
    step(); step(); step();
    chk("R11 quiet after edges", 16'(dout_en), 16'd0);
    snooze = 0; idle(); #1;
    chk("R11 pipeline held drive", 16'(dout_en), 16'd1);
    chk("R11 pipeline held data", dout, ref_mem[20]);
    step();
    chk("R11 burst position held", dout, ref_mem[20]);
    deselect();
    load(6'd33); step();
    chk("R11 no write in snooze", dout, ref_mem[33]);
    load(6'd20); step();
    chk("R11 data retained", dout, ref_mem[20]);
    deselect();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule